// File: doc/BRIEF.md
# Virtual Message Queue Translator

This block turns virtual queue names into physical ones on both sides of a network interface. On the sending side, each outgoing message header carries a virtual destination number; the block looks it up in a table. The table entry gives the destination node and the virtual receive queue number that the message will carry across the network. An entry that is not marked valid causes the message to be dropped, and a one-cycle miss flag is raised.

On the receiving side, the virtual receive queue number of an arriving header is looked up in a second table. The logical queue space holds 512 queues, but only a handful of them can live in hardware at once. A resident entry names one of the sixteen hardware queues. A non-resident entry sends the message to hardware queue 15, which belongs to the service processor. The service processor emulates every queue that is not resident. Because only table contents decide where a message goes, a queue can be moved in or out of hardware without the application knowing.

Both tables are written through a single write port. Each header stream passes through a one-cycle registered stage with valid/ready handshaking. An opaque tag rides along unchanged with each header.

Top module: `vmq_xlate`

## Requirements
- R1: After synchronous active-low reset, both output valids and `tx_miss` are low, both input readies are high, every transmit entry is invalid and every receive entry is non-resident.
- R2: A transmit header accepted on an edge whose table entry is valid appears on the next edge on `tx_out_*`. It carries the entry's node id and receive queue number, with the tag unchanged.
- R3: A transmit header whose entry is invalid is dropped (no `tx_out_valid`), and `tx_miss` is high for exactly the one cycle after its acceptance edge.
- R4: A receive header whose entry is resident leaves one edge after acceptance, with `rx_out_hwq` equal to the entry's 4-bit index, `rx_out_divert` low and the tag unchanged.
- R5: A receive header whose entry is non-resident leaves with `rx_out_divert` high and `rx_out_hwq` equal to 15.
- R6: With `cfg_we` high, `cfg_sel_rx`=0 writes transmit entry `cfg_addr` as {valid at bit 17, node at bits 16:9, receive queue at bits 8:0}. `cfg_sel_rx`=1 writes receive entry `cfg_addr` as {resident at bit 4, index at bits 3:0}, and the upper bits are ignored. A write to one table leaves the other unchanged.
- R7: A write in the same cycle as a lookup of the same entry is not seen by that lookup. It is seen by every later lookup.
- R8: While an output is valid and its ready is low, that output's fields stay stable and its input ready is low. When the output is ready again, no accepted header is lost or reordered.
- R9: Rewriting an entry (remapping, evicting or invalidating it) changes the translation of later headers for that entry only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Table write strobe |
| cfg_sel_rx | input | 1 | 0 selects transmit table, 1 selects receive table |
| cfg_addr | input | 9 | Entry written |
| cfg_wdata | input | 18 | Entry contents (layout in R6) |
| tx_in_valid | input | 1 | Transmit header present |
| tx_in_ready | output | 1 | Transmit header accepted when valid |
| tx_in_vdest | input | 9 | Virtual destination number |
| tx_in_tag | input | 16 | Opaque header tag |
| tx_out_valid | output | 1 | Translated transmit header present |
| tx_out_ready | input | 1 | Downstream accepts transmit header |
| tx_out_node | output | 8 | Destination node id |
| tx_out_rq | output | 9 | Virtual receive queue number |
| tx_out_tag | output | 16 | Tag carried through |
| tx_miss | output | 1 | One-cycle pulse for a dropped header |
| rx_in_valid | input | 1 | Receive header present |
| rx_in_ready | output | 1 | Receive header accepted when valid |
| rx_in_rq | input | 9 | Virtual receive queue number |
| rx_in_tag | input | 16 | Opaque header tag |
| rx_out_valid | output | 1 | Routed receive header present |
| rx_out_ready | input | 1 | Downstream accepts receive header |
| rx_out_hwq | output | 4 | Hardware queue index |
| rx_out_divert | output | 1 | Header goes to the service processor |
| rx_out_tag | output | 16 | Tag carried through |

## Verification
The bench looks up entries 0 and 511, so that a wrong address width or an off-by-one in the tables shows up as a miss or as a wrong node. It writes an entry and looks it up in the same cycle. A design that forwards the new write data would return the new node one lookup too early. It stalls the transmit output while a second header waits. A design that overwrote its output register would lose the first tag, and one that kept accepting would drop a header. It also evicts a resident queue and invalidates a transmit entry. A design that ignored the resident or valid bit would keep routing to the old hardware queue or keep sending rather than raising the miss pulse.

// File: rtl/vmq_pkg.sv
// Package vmq_pkg
// Shared constants for the virtual message queue translator.
// Assumes: consumers use these only as defaults for their own parameters.
package vmq_pkg;
    localparam int unsigned VMQ_NQ     = 512;
    localparam int unsigned VMQ_NODE_W = 8;
    localparam int unsigned VMQ_HWQ_N  = 16;
    localparam int unsigned VMQ_TAG_W  = 16;
endpackage

// File: rtl/vmq_table.sv
// Module vmq_table
// Flop-based translation table: one synchronous write port and one
// combinational read port. A read in the cycle of a write to the same
// entry returns the old contents.
// Assumes: reset clears every entry to zero (invalid / non-resident).
module vmq_table #(
    parameter int unsigned DEPTH = 512,
    parameter int unsigned W     = 18,
    localparam int unsigned AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] mem [DEPTH];

    // Store entries; reset clears all of them.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // Lookup read of the current contents.
    always_comb rdata = mem[raddr];

    // R9
    table_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(we) && raddr == $past(waddr)) |-> rdata == $past(wdata));
endmodule

// File: rtl/vmq_stage.sv
// Module vmq_stage
// One-entry registered pipeline stage with valid/ready handshaking.
// An accepted item with in_keep low is consumed but not emitted.
// Assumes: out_data is only meaningful while out_valid is high.
module vmq_stage #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic         in_keep,
    input  logic [W-1:0] in_data,
    output logic         in_ready,
    output logic         out_valid,
    input  logic         out_ready,
    output logic [W-1:0] out_data
);
    // Accept when empty or draining this cycle.
    always_comb in_ready = !out_valid || out_ready;

    // Load, drop or drain the stage register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else if (in_valid && in_ready) begin
            out_valid <= in_keep;
            if (in_keep) out_data <= in_data;
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end

    // R8
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
    // R1
    reset_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> !out_valid);
endmodule

// File: rtl/vmq_xlate.sv
// Module vmq_xlate
// Virtual message queue translator. The transmit path maps a virtual
// destination to {node, receive queue}; the receive path maps a receive
// queue to a resident hardware queue or to the service-processor queue.
// Assumes: the highest hardware queue index is reserved for the service
// processor; table writes never stall lookups.
module vmq_xlate #(
    parameter int unsigned NQ     = vmq_pkg::VMQ_NQ,
    parameter int unsigned NODE_W = vmq_pkg::VMQ_NODE_W,
    parameter int unsigned HWQ_N  = vmq_pkg::VMQ_HWQ_N,
    parameter int unsigned TAG_W  = vmq_pkg::VMQ_TAG_W
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cfg_we,
    input  logic                         cfg_sel_rx,
    input  logic [$clog2(NQ)-1:0]        cfg_addr,
    input  logic [NODE_W+$clog2(NQ):0]   cfg_wdata,
    input  logic                         tx_in_valid,
    output logic                         tx_in_ready,
    input  logic [$clog2(NQ)-1:0]        tx_in_vdest,
    input  logic [TAG_W-1:0]             tx_in_tag,
    output logic                         tx_out_valid,
    input  logic                         tx_out_ready,
    output logic [NODE_W-1:0]            tx_out_node,
    output logic [$clog2(NQ)-1:0]        tx_out_rq,
    output logic [TAG_W-1:0]             tx_out_tag,
    output logic                         tx_miss,
    input  logic                         rx_in_valid,
    output logic                         rx_in_ready,
    input  logic [$clog2(NQ)-1:0]        rx_in_rq,
    input  logic [TAG_W-1:0]             rx_in_tag,
    output logic                         rx_out_valid,
    input  logic                         rx_out_ready,
    output logic [$clog2(HWQ_N)-1:0]     rx_out_hwq,
    output logic                         rx_out_divert,
    output logic [TAG_W-1:0]             rx_out_tag
);
    localparam int unsigned QID_W  = $clog2(NQ);
    localparam int unsigned HWQ_W  = $clog2(HWQ_N);
    localparam int unsigned TXE_W  = 1 + NODE_W + QID_W;
    localparam int unsigned RXE_W  = 1 + HWQ_W;
    localparam int unsigned TXO_W  = NODE_W + QID_W + TAG_W;
    localparam int unsigned RXO_W  = 1 + HWQ_W + TAG_W;
    localparam logic [HWQ_W-1:0] SVC_IDX = HWQ_W'(HWQ_N - 1);

    logic [TXE_W-1:0] tx_ent;
    logic [RXE_W-1:0] rx_ent;
    logic             tx_hit;
    logic             tx_acc;
    logic             rx_res;
    logic [HWQ_W-1:0] rx_sel_q;
    logic [TXO_W-1:0] tx_stage_in, tx_stage_out;
    logic [RXO_W-1:0] rx_stage_in, rx_stage_out;

    vmq_table #(.DEPTH(NQ), .W(TXE_W)) u_tx_tbl (
        .clk(clk), .rst_n(rst_n),
        .we(cfg_we && !cfg_sel_rx), .waddr(cfg_addr), .wdata(cfg_wdata),
        .raddr(tx_in_vdest), .rdata(tx_ent)
    );

    vmq_table #(.DEPTH(NQ), .W(RXE_W)) u_rx_tbl (
        .clk(clk), .rst_n(rst_n),
        .we(cfg_we && cfg_sel_rx), .waddr(cfg_addr), .wdata(cfg_wdata[RXE_W-1:0]),
        .raddr(rx_in_rq), .rdata(rx_ent)
    );

    // Decode transmit entry into hit and the header to forward.
    always_comb begin
        tx_hit      = tx_ent[TXE_W-1];
        tx_stage_in = {tx_ent[TXE_W-2:0], tx_in_tag};
    end

    // Pick resident hardware queue or the service-processor queue.
    always_comb begin
        rx_res      = rx_ent[HWQ_W];
        rx_sel_q    = rx_res ? rx_ent[HWQ_W-1:0] : SVC_IDX;
        rx_stage_in = {!rx_res, rx_sel_q, rx_in_tag};
    end

    vmq_stage #(.W(TXO_W)) u_tx_stage (
        .clk(clk), .rst_n(rst_n),
        .in_valid(tx_in_valid), .in_keep(tx_hit), .in_data(tx_stage_in),
        .in_ready(tx_in_ready), .out_valid(tx_out_valid),
        .out_ready(tx_out_ready), .out_data(tx_stage_out)
    );

    vmq_stage #(.W(RXO_W)) u_rx_stage (
        .clk(clk), .rst_n(rst_n),
        .in_valid(rx_in_valid), .in_keep(1'b1), .in_data(rx_stage_in),
        .in_ready(rx_in_ready), .out_valid(rx_out_valid),
        .out_ready(rx_out_ready), .out_data(rx_stage_out)
    );

    // Split the stage registers onto the output ports.
    always_comb begin
        {tx_out_node, tx_out_rq, tx_out_tag}     = tx_stage_out;
        {rx_out_divert, rx_out_hwq, rx_out_tag}  = rx_stage_out;
        tx_acc = tx_in_valid && tx_in_ready;
    end

    // Pulse the miss flag for one cycle after a dropped header.
    always_ff @(posedge clk) begin
        if (!rst_n) tx_miss <= 1'b0;
        else        tx_miss <= tx_acc && !tx_hit;
    end

    // R3
    miss_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_miss |-> $past(tx_in_valid && tx_in_ready));
    // R3
    miss_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_miss |-> !tx_out_valid);
    // R5
    svc_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_in_valid && rx_in_ready && !rx_ent[HWQ_W]) |=>
            (rx_out_valid && rx_out_divert && rx_out_hwq == SVC_IDX));
endmodule

// File: tb/test_vmq_xlate.sv
`timescale 1ns/1ps
module test_vmq_xlate;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0, cfg_sel_rx = 1'b0;
    logic [8:0]  cfg_addr = '0;
    logic [17:0] cfg_wdata = '0;
    logic        tx_in_valid = 1'b0, tx_out_ready = 1'b1;
    logic [8:0]  tx_in_vdest = '0;
    logic [15:0] tx_in_tag = '0;
    logic        rx_in_valid = 1'b0, rx_out_ready = 1'b1;
    logic [8:0]  rx_in_rq = '0;
    logic [15:0] rx_in_tag = '0;
    logic        tx_in_ready, tx_out_valid, tx_miss;
    logic [7:0]  tx_out_node;
    logic [8:0]  tx_out_rq;
    logic [15:0] tx_out_tag;
    logic        rx_in_ready, rx_out_valid, rx_out_divert;
    logic [3:0]  rx_out_hwq;
    logic [15:0] rx_out_tag;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    vmq_xlate i_vmq_xlate (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_sel_rx(cfg_sel_rx), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .tx_in_valid(tx_in_valid), .tx_in_ready(tx_in_ready), .tx_in_vdest(tx_in_vdest),
        .tx_in_tag(tx_in_tag), .tx_out_valid(tx_out_valid), .tx_out_ready(tx_out_ready),
        .tx_out_node(tx_out_node), .tx_out_rq(tx_out_rq), .tx_out_tag(tx_out_tag),
        .tx_miss(tx_miss),
        .rx_in_valid(rx_in_valid), .rx_in_ready(rx_in_ready), .rx_in_rq(rx_in_rq),
        .rx_in_tag(rx_in_tag), .rx_out_valid(rx_out_valid), .rx_out_ready(rx_out_ready),
        .rx_out_hwq(rx_out_hwq), .rx_out_divert(rx_out_divert), .rx_out_tag(rx_out_tag)
    );

    // op: 0 write tx entry, 1 write rx entry, 2 tx lookup, 3 rx lookup
    // tx exp = {node, rq}; rx exp = {divert, hwq}
    typedef struct packed {
        logic [1:0]  op;
        logic [8:0]  addr;
        logic [17:0] data;
        logic [16:0] exp;
        logic        miss;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VEC [NV] = '{
        '{2'd2, 9'd5,   18'h0,                       17'h0,               1'b1}, // R1 tx empty
        '{2'd3, 9'd5,   18'h0,                       17'h1F,              1'b0}, // R1 rx empty
        '{2'd0, 9'd5,   {1'b1, 8'h2A, 9'd300},       17'h0,               1'b0},
        '{2'd2, 9'd5,   18'h0,                       {8'h2A, 9'd300},     1'b0}, // R2
        '{2'd1, 9'd300, {13'h1FFF, 1'b1, 4'd3},      17'h0,               1'b0},
        '{2'd3, 9'd300, 18'h0,                       17'h03,              1'b0}, // R4
        '{2'd3, 9'd5,   18'h0,                       17'h1F,              1'b0}, // R6
        '{2'd0, 9'd511, {1'b1, 8'hFF, 9'd0},         17'h0,               1'b0},
        '{2'd2, 9'd511, 18'h0,                       {8'hFF, 9'd0},       1'b0}, // R2
        '{2'd2, 9'd0,   18'h0,                       17'h0,               1'b1}, // R3
        '{2'd1, 9'd300, {13'h0, 1'b0, 4'd3},         17'h0,               1'b0},
        '{2'd3, 9'd300, 18'h0,                       17'h1F,              1'b0}, // R5 R9
        '{2'd0, 9'd5,   {1'b0, 8'h2A, 9'd300},       17'h0,               1'b0},
        '{2'd2, 9'd5,   18'h0,                       17'h0,               1'b1}, // R9
        '{2'd3, 9'd511, 18'h0,                       17'h1F,              1'b0}  // R6
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic sel, input logic [8:0] a, input logic [17:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel_rx = sel; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic tx_send(input logic [8:0] a, input logic [15:0] tag);
        @(negedge clk);
        tx_in_valid = 1'b1; tx_in_vdest = a; tx_in_tag = tag;
        @(negedge clk);
        tx_in_valid = 1'b0;
    endtask

    task automatic rx_send(input logic [8:0] a, input logic [15:0] tag);
        @(negedge clk);
        rx_in_valid = 1'b1; rx_in_rq = a; rx_in_tag = tag;
        @(negedge clk);
        rx_in_valid = 1'b0;
    endtask

    task automatic tx_expect(input string req, input logic [16:0] exp, input logic [15:0] tag);
        chk({req, " tx_out_valid"}, 32'(tx_out_valid), 32'd1);
        chk({req, " tx node/rq"}, 32'({tx_out_node, tx_out_rq}), 32'(exp));
        chk({req, " tx tag"}, 32'(tx_out_tag), 32'(tag));
        chk({req, " tx_miss low"}, 32'(tx_miss), 32'd0);
    endtask

    initial begin
        #(200000 * 5);
        fails++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state at the ports
        chk("R1 tx_out_valid", 32'(tx_out_valid), 32'd0);
        chk("R1 rx_out_valid", 32'(rx_out_valid), 32'd0);
        chk("R1 tx_miss", 32'(tx_miss), 32'd0);
        chk("R1 tx_in_ready", 32'(tx_in_ready), 32'd1);
        chk("R1 rx_in_ready", 32'(rx_in_ready), 32'd1);

        for (int i = 0; i < NV; i++) begin
            case (VEC[i].op)
                2'd0: cfg_write(1'b0, VEC[i].addr, VEC[i].data);
                2'd1: cfg_write(1'b1, VEC[i].addr, VEC[i].data);
                2'd2: begin
                    tx_send(VEC[i].addr, 16'(i));
                    if (VEC[i].miss) begin
                        chk($sformatf("R3 vec%0d dropped", i), 32'(tx_out_valid), 32'd0);
                        chk($sformatf("R3 vec%0d miss", i), 32'(tx_miss), 32'd1);
                        @(negedge clk);
                        chk($sformatf("R3 vec%0d miss one cycle", i), 32'(tx_miss), 32'd0);
                    end else begin
                        tx_expect($sformatf("R2 vec%0d", i), VEC[i].exp, 16'(i));
                    end
                end
                default: begin
                    rx_send(VEC[i].addr, 16'(i + 100));
                    chk($sformatf("R4 R5 vec%0d rx valid", i), 32'(rx_out_valid), 32'd1);
                    chk($sformatf("R4 R5 vec%0d rx route", i),
                        32'({rx_out_divert, rx_out_hwq}), 32'(VEC[i].exp));
                    chk($sformatf("R4 vec%0d rx tag", i), 32'(rx_out_tag), 32'(i + 100));
                end
            endcase
        end

        // R7 write and lookup of entry 9 in one cycle
        cfg_write(1'b0, 9'd9, {1'b1, 8'd11, 9'd22});
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel_rx = 1'b0; cfg_addr = 9'd9; cfg_wdata = {1'b1, 8'd33, 9'd44};
        tx_in_valid = 1'b1; tx_in_vdest = 9'd9; tx_in_tag = 16'hA5A5;
        @(negedge clk);
        cfg_we = 1'b0; tx_in_valid = 1'b0;
        tx_expect("R7 same-cycle old", {8'd11, 9'd22}, 16'hA5A5);
        tx_send(9'd9, 16'h5A5A);
        tx_expect("R7 next lookup new", {8'd33, 9'd44}, 16'h5A5A);

        // R8 stall: second header waits, first held stable
        @(negedge clk);
        tx_out_ready = 1'b0;
        tx_in_valid = 1'b1; tx_in_vdest = 9'd9; tx_in_tag = 16'h1111;
        @(negedge clk);
        tx_in_vdest = 9'd511; tx_in_tag = 16'h2222;
        tx_expect("R8 first held", {8'd33, 9'd44}, 16'h1111);
        chk("R8 in_ready low", 32'(tx_in_ready), 32'd0);
        @(negedge clk);
        tx_expect("R8 still held", {8'd33, 9'd44}, 16'h1111);
        chk("R8 in_ready still low", 32'(tx_in_ready), 32'd0);
        tx_out_ready = 1'b1;
        @(negedge clk);
        tx_in_valid = 1'b0;
        tx_expect("R8 second follows", {8'hFF, 9'd0}, 16'h2222);
        @(negedge clk);
        chk("R8 drained", 32'(tx_out_valid), 32'd0);

        // R1 reset clears table contents
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        tx_send(9'd9, 16'h3333);
        chk("R1 tx entry cleared", 32'(tx_miss), 32'd1);
        rx_send(9'd300, 16'h4444);
        chk("R1 rx entry cleared", 32'({rx_out_divert, rx_out_hwq}), 32'h1F);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule